// File: doc/BRIEF.md
# Saturating Hit Multiplicity Merger

This block combines the per-condition hit reports of eight cluster-processing units into a multiplicity count for each of sixteen hit conditions. Every unit reports, for each condition, a 2-bit value that gives how many hits it saw (zero, one or two). A code of three is treated as two. Once per bunch-crossing tick, the block adds the reports for each condition across all units. It then clamps the total to the largest value a 3-bit count can hold.

The sixteen counts are split into two groups of eight. Each group is packed into a 25-bit word that carries one odd-parity bit, and the two words go to a left and a right downstream merger. The adder tree, the clamp and the packing sit before one register stage. A word therefore appears one tick after its inputs are marked valid. On ticks with no valid input, the output words keep their last value.

Top module: `hit_mult_merger`

## Requirements
- R1: While `rst` is high, `out_valid` is low on the next edge, and both `left_word` and `right_word` are all zeros.
- R2: The count for condition c is the sum over all eight units of that unit's 2-bit report for condition c. Unit u's report for condition c sits at `hits_in[(u*16+c)*2 +: 2]`.
- R3: A count never wraps. Any sum above 7 is output as 7, and a sum of exactly 7 is output unchanged.
- R4: A unit report of code 3 adds 2 to the sum, the same as code 2.
- R5: Conditions 0 to 7 go to `left_word` and conditions 8 to 15 go to `right_word`. Within a word, the k-th condition of its group occupies bits 3k+2:3k.
- R6: Bit 24 of each output word is set so that the word as a whole has an odd number of ones.
- R7: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. The words shown in that cycle come from the inputs of that earlier cycle.
- R8: A cycle with `in_valid` low leaves both output words unchanged, whatever `hits_in` holds in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `hits_in` as one tick's reports |
| hits_in | input | 256 | 2-bit hit reports, unit-major and condition-minor |
| out_valid | output | 1 | Output words updated this cycle |
| left_word | output | 25 | Counts for conditions 0-7 plus parity bit 24 |
| right_word | output | 25 | Counts for conditions 8-15 plus parity bit 24 |

## Verification
The hardest case to reach from the ports is the clamp boundary. A condition's sum has to land exactly on 7 or 8 while other conditions in the same word sit at unrelated values. That is the only way to show that saturation is applied per field and does not leak into neighbouring fields. The stimulus sweeps every condition through directed totals from 0 to 16, built from mixes of codes 1, 2 and 3 across the units. Each of those sweeps runs on top of pseudo-random background traffic on the other conditions, and is followed by dense and sparse random patterns. Idle cycles that carry garbage on `hits_in` are mixed in to show that the outputs hold.

// File: rtl/hit_mult_pkg.sv
package hit_mult_pkg;
  // width of one unit's per-condition report
  localparam int HIT_W = 2;
  // largest meaningful report value
  localparam logic [HIT_W-1:0] HIT_MAX = 2'd2;

  // code 3 is folded onto the maximum legal report
  function automatic logic [HIT_W-1:0] unit_clamp(input logic [HIT_W-1:0] v);
    return (v > HIT_MAX) ? HIT_MAX : v;
  endfunction
endpackage

// File: rtl/cond_summer.sv
module cond_summer
  import hit_mult_pkg::*;
#(
  parameter int N_UNITS = 8,
  parameter int CNT_W   = 3
) (
  input  logic [N_UNITS*HIT_W-1:0] reports,
  output logic [CNT_W-1:0]         count
);
  localparam int SUM_MAX = N_UNITS * int'(HIT_MAX);
  localparam int SUM_W   = $clog2(SUM_MAX + 1);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = '0;
    for (int u = 0; u < N_UNITS; u++) begin
      sum = sum + SUM_W'(unit_clamp(reports[u*HIT_W +: HIT_W]));
    end
  end

  generate
    if (SUM_W > CNT_W) begin : g_clamp
      always_comb count = (sum > SUM_W'(CNT_MAX)) ? CNT_W'(CNT_MAX) : sum[CNT_W-1:0];
    end else begin : g_direct
      always_comb count = CNT_W'(sum);
    end
  endgenerate
endmodule

// File: rtl/parity_packer.sv
module parity_packer #(
  parameter int GROUP = 8,
  parameter int CNT_W = 3
) (
  input  logic [GROUP*CNT_W-1:0] counts,
  output logic [GROUP*CNT_W:0]   word
);
  // odd parity: total ones in the word is odd
  always_comb word = {~^counts, counts};
endmodule

// File: rtl/hit_mult_merger.sv
module hit_mult_merger
  import hit_mult_pkg::*;
#(
  parameter int N_UNITS = 8,
  parameter int N_COND  = 16,
  parameter int CNT_W   = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic [N_UNITS*N_COND*HIT_W-1:0]   hits_in,
  output logic                              out_valid,
  output logic [(N_COND/2)*CNT_W:0]         left_word,
  output logic [(N_COND/2)*CNT_W:0]         right_word
);
  localparam int GROUP  = N_COND / 2;
  localparam int WORD_W = GROUP * CNT_W + 1;
  localparam int BUS_W  = N_UNITS * HIT_W;

  logic [BUS_W-1:0]         cond_bus  [N_COND];
  logic [CNT_W-1:0]         cnt       [N_COND];
  logic [GROUP*CNT_W-1:0]   grp_cnt   [2];
  logic [WORD_W-1:0]        grp_word  [2];

  // regroup the unit-major input into one bus per condition
  for (genvar c = 0; c < N_COND; c++) begin : g_cond
    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
      assign cond_bus[c][u*HIT_W +: HIT_W] = hits_in[(u*N_COND + c)*HIT_W +: HIT_W];
    end

    cond_summer #(.N_UNITS(N_UNITS), .CNT_W(CNT_W)) u_sum (
      .reports(cond_bus[c]),
      .count  (cnt[c])
    );
  end

  // side 0 = left (low conditions), side 1 = right (high conditions)
  for (genvar s = 0; s < 2; s++) begin : g_side
    for (genvar k = 0; k < GROUP; k++) begin : g_fld
      assign grp_cnt[s][k*CNT_W +: CNT_W] = cnt[s*GROUP + k];
    end

    parity_packer #(.GROUP(GROUP), .CNT_W(CNT_W)) u_pack (
      .counts(grp_cnt[s]),
      .word  (grp_word[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      left_word  <= '0;
      right_word <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        left_word  <= grp_word[0];
        right_word <= grp_word[1];
      end
    end
  end
endmodule

// File: rtl/hit_mult_merger_chk.sv
module hit_mult_merger_chk #(
  parameter int N_UNITS = 8,
  parameter int N_COND  = 16,
  parameter int CNT_W   = 3
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            in_valid,
  input logic [N_UNITS*N_COND*2-1:0]     hits_in,
  input logic                            out_valid,
  input logic [(N_COND/2)*CNT_W:0]       left_word,
  input logic [(N_COND/2)*CNT_W:0]       right_word
);
  localparam int CB = (N_COND/2)*CNT_W;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && left_word == '0 && right_word == '0));

  // R6
  odd_parity_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (^left_word && ^right_word));

  // R7
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R7
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(left_word) && $stable(right_word)));

  // R2
  zero_input_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hits_in == '0) |=> (left_word[CB-1:0] == '0 && right_word[CB-1:0] == '0));
endmodule

bind hit_mult_merger hit_mult_merger_chk #(
  .N_UNITS(N_UNITS), .N_COND(N_COND), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .hits_in(hits_in),
  .out_valid(out_valid), .left_word(left_word), .right_word(right_word)
);

// File: tb/sim_hit_mult_merger.sv
module sim_hit_mult_merger;
  localparam int NU = 8;
  localparam int NC = 16;
  localparam int W  = NU*NC*2;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [W-1:0]  hits_in;
  logic          out_valid;
  logic [24:0]   left_word, right_word;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [31:0] seed = 32'h1357_9bdf;

  always #5 clk = ~clk;

  hit_mult_merger u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .hits_in(hits_in),
    .out_valid(out_valid), .left_word(left_word), .right_word(right_word)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  // R2, R3, R4, R5, R6 model
  function automatic logic [24:0] model(input logic [W-1:0] h, input int side);
    logic [24:0] w = '0;
    for (int k = 0; k < 8; k++) begin
      int c = side*8 + k;
      int s = 0;
      for (int u = 0; u < NU; u++) begin
        int v = int'(h[(u*NC + c)*2 +: 2]);
        s += (v > 2) ? 2 : v;
      end
      if (s > 7) s = 7;
      w[3*k +: 3] = 3'(s);
    end
    w[24] = ~^w[23:0];
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd_vec();
    logic [W-1:0] v;
    for (int i = 0; i < W/32; i++) begin
      seed = nxt(seed);
      v[i*32 +: 32] = seed;
    end
    return v;
  endfunction

  // apply one valid tick and check it on the following cycle (R7)
  task automatic tick(input logic [W-1:0] h, input string req);
    in_valid = 1'b1;
    hits_in  = h;
    @(negedge clk);
    chk({req, "/R7 valid"}, 32'(out_valid), 32'd1);
    chk({req, " left"},  32'(left_word),  32'(model(h, 0)));
    chk({req, " right"}, 32'(right_word), 32'(model(h, 1)));
  endtask

  // set one condition's total from a mix of codes over units
  function automatic logic [W-1:0] set_cond(input logic [W-1:0] base, input int c,
                                            input int total, input int use3);
    logic [W-1:0] h = base;
    int rem = total;
    for (int u = 0; u < NU; u++) begin
      int v = (rem >= 2) ? 2 : rem;
      if (v == 2 && use3 != 0 && (u % 2 == 0)) v = 3;
      h[(u*NC + c)*2 +: 2] = 2'(v);
      rem -= (v > 2) ? 2 : v;
    end
    return h;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [24:0] hl, hr;
    rst = 1'b1; in_valid = 1'b0; hits_in = '1;
    @(negedge clk); @(negedge clk);
    // R1
    chk("R1 valid", 32'(out_valid), 32'd0);
    chk("R1 left",  32'(left_word), 32'd0);
    chk("R1 right", 32'(right_word), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R2 zero and single hits; R5 field placement
    tick('0, "R2 zero");
    for (int c = 0; c < NC; c++) begin
      logic [W-1:0] h = '0;
      h[((c % NU)*NC + c)*2 +: 2] = 2'd1;
      tick(h, "R5 single");
    end

    // R3 boundaries per condition with random background, R4 code 3
    for (int c = 0; c < NC; c++) begin
      for (int t = 0; t <= 16; t++) begin
        tick(set_cond(rnd_vec() & rnd_vec(), c, t, t % 2), "R3 sweep");
      end
    end
    tick({W/2{2'd3}}, "R4 all three");
    tick({W/2{2'd2}}, "R3 all two");

    // R6/R2 random dense and sparse
    for (int i = 0; i < 200; i++) begin
      tick((i % 2) ? rnd_vec() : (rnd_vec() & rnd_vec() & rnd_vec()), "R6 random");
    end

    // R8 idle cycles with garbage
    hl = left_word; hr = right_word;
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b0;
      hits_in  = rnd_vec();
      @(negedge clk);
      chk("R8 valid low", 32'(out_valid), 32'd0);
      chk("R8 left hold", 32'(left_word), 32'(hl));
      chk("R8 right hold", 32'(right_word), 32'(hr));
    end
    tick(rnd_vec(), "R7 after idle");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule